// File: doc/BRIEF.md
# Supervisory Reset Timeout Controller

This block generates the system reset for a microcontroller subsystem. It combines three trigger sources: a supply-good flag from an analog comparator, an active-low pushbutton input, and the sensed level of a shared active-low reset pin. Whenever any source fires, the block asserts reset. It keeps reset asserted until a fixed timeout has elapsed with every source quiet. All three inputs are asynchronous and are brought into the clock domain by synchronizer chains of equal depth.

Each source follows its own rule. The supply flag is level-held: reset stays asserted as long as the supply is bad. The pushbutton is also level-held, but a filter first rejects lows shorter than a programmable number of cycles. The shared pin is edge-triggered. A falling edge seen while the block is idle starts a complete timeout, however short the external pulse was. Edges that the block causes itself by driving the pin are ignored.

The block has four outputs driven from the same state: an active-high reset, its active-low complement, an enable for the open-drain pad that pulls the shared pin low, and an inhibit that stops the companion memory interface from running transfers or starting writes. The timeout, the filter length and the synchronizer depth are parameters counted in clock cycles.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, the reset outputs are asserted. After `rst_n` returns high with healthy inputs, `rst_active_o` stays high for exactly SYNC_STAGES+TIMEOUT_CYC-1 cycles, counting from the first rising edge that samples `rst_n` high.
- R2: A low on `supply_ok_i` asserts `rst_active_o` after the (SYNC_STAGES+1)th rising edge that samples it. Reset then stays high for as long as the input stays low.
- R3: When `supply_ok_i` returns high, `rst_active_o` stays high for exactly SYNC_STAGES+TIMEOUT_CYC-1 cycles, counting from the first edge that samples the high.
- R4: A low on `mr_n_i` held for at least MR_FILT_CYC cycles asserts reset. After the release, `rst_active_o` stays high for exactly SYNC_STAGES+TIMEOUT_CYC cycles, counting from the first edge that samples the high.
- R5: A low on `mr_n_i` that lasts fewer than MR_FILT_CYC cycles produces no reset. A low of exactly MR_FILT_CYC cycles produces one full timeout of TIMEOUT_CYC cycles.
- R6: A falling edge on `pin_sense_n_i` while the block is idle asserts reset after the (SYNC_STAGES+1)th edge. Reset then stays high for exactly TIMEOUT_CYC cycles, even for a one-cycle external pulse.
- R7: Only a falling edge on the shared pin counts as a trigger. Holding the pin low longer does not extend the reset. The block's own pull on the pin, and the release of that pull, cause no further reset.
- R8: A trigger that arrives on the very edge at which the timeout would expire wins. Reset stays asserted and the timeout restarts.
- R9: `rst_active_n_o` is always the complement of `rst_active_o`. `pin_pull_o` and `mem_inhibit_o` are high exactly when reset is active.
- R10: Whenever reset is released, it has been held for at least TIMEOUT_CYC consecutive cycles.
- R11: When several sources are active together, reset is released only on the timeout that follows the last source to go quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok_i | input | 1 | Supply above threshold (asynchronous) |
| mr_n_i | input | 1 | Pushbutton reset, active low (asynchronous) |
| pin_sense_n_i | input | 1 | Sensed level of the shared reset pin, low = asserted |
| pin_pull_o | output | 1 | Pad enable; 1 pulls the shared reset pin low |
| rst_active_o | output | 1 | System reset, active high |
| rst_active_n_o | output | 1 | System reset, active low |
| mem_inhibit_o | output | 1 | Blocks memory transfers and write starts |

## Verification
Two events can land on the same edge: the expiry of a running timeout and a new trigger. The bench releases the pushbutton and counts cycles. It then drops the supply flag at exactly the moment that makes the synchronized low reach the timer on the edge where the count would end. The check passes only if reset never drops during that window, and the following release then takes exactly one full supply timeout.

// File: rtl/sup_rst_pkg.sv
// Package: trigger-source bundle shared by the reset controller blocks.
// Assumes: every source is already synchronous to the system clock.
package sup_rst_pkg;

    typedef struct packed {
        logic supply_low;
        logic button;
        logic pin_fall;
    } trig_src_t;

    // True when any source requests reset in this cycle.
    function automatic logic any_src(input trig_src_t t);
        return t.supply_low | t.button | t.pin_fall;
    endfunction

endpackage

// File: rtl/sup_rst_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; RST_VAL is the level reported during block reset.
module sup_rst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sup_btn_filter.sv
// Spike filter for the active-low pushbutton. The button counts as
// pressed only after FILT_LEN consecutive low samples, and it releases
// on the first high sample.
// Assumes: btn_n_i is synchronous; FILT_LEN >= 1.
module sup_btn_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n_i,
    output logic pressed_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [CW-1:0] low_cnt_q;

    // Count consecutive low samples, saturating at FILT_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt_q <= '0;
        else if (btn_n_i)        low_cnt_q <= '0;
        else if (low_cnt_q != FULL) low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign pressed_o = (low_cnt_q == FULL);
endmodule

// File: rtl/sup_pin_edge.sv
// Falling-edge detector for the shared reset pin. Edges are ignored
// while the block itself pulls the pin, so the block's own drive
// cannot retrigger it.
// Assumes: pin_n_i is synchronous; own_pull_i is the pad enable.
module sup_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic own_pull_i,
    output logic fall_o
);
    logic prev_q;

    // Remember last sensed level; starts high (pin released).
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_n_i;
    end

    assign fall_o = prev_q & ~pin_n_i & ~own_pull_i;
endmodule

// File: rtl/sup_rst_timer.sv
// Reset timeout engine. Any trigger clears the counter and holds reset.
// Reset drops after TIMEOUT cycles with no trigger. A trigger on the
// expiry edge takes priority over the expiry.
// Assumes: TIMEOUT >= 2.
module sup_rst_timer #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  sup_rst_pkg::trig_src_t src_i,
    output logic active_o
);
    localparam int CW = $clog2(TIMEOUT);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          trig;

    assign trig = sup_rst_pkg::any_src(src_i);

    // Restart on trigger, otherwise count down the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (trig) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q == LAST) begin
                cnt_q    <= '0;
                active_q <= 1'b0;
            end else begin
                cnt_q    <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/sup_reset_ctrl.sv
// Supervisory reset controller top. It synchronizes three trigger
// inputs, applies per-source rules (level, filtered level, edge) and
// drives the reset, pad-enable and memory-inhibit outputs from one
// state bit.
// Assumes: the pad is open drain, so pin_sense_n_i reads low whenever
// pin_pull_o is high.
module sup_reset_ctrl #(
    parameter int TIMEOUT_CYC = 50_000_000,
    parameter int MR_FILT_CYC = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic mr_n_i,
    input  logic pin_sense_n_i,
    output logic pin_pull_o,
    output logic rst_active_o,
    output logic rst_active_n_o,
    output logic mem_inhibit_o
);
    import sup_rst_pkg::*;

    localparam int NSRC = 3;
    // Reset levels: supply reads bad, button and pin read released.
    localparam logic [NSRC-1:0] SYNC_RST = 3'b110;

    logic [NSRC-1:0] raw_in;
    logic [NSRC-1:0] syn_in;
    logic            btn_pressed;
    logic            pin_fall;
    logic            active;
    trig_src_t       src;

    assign raw_in = {pin_sense_n_i, mr_n_i, supply_ok_i};

    for (genvar i = 0; i < NSRC; i++) begin : g_sync
        sup_rst_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SYNC_RST[i])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_in[i]),
            .q_o   (syn_in[i])
        );
    end

    sup_btn_filter #(.FILT_LEN(MR_FILT_CYC)) u_btn (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_n_i   (syn_in[1]),
        .pressed_o (btn_pressed)
    );

    sup_pin_edge u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n_i    (syn_in[2]),
        .own_pull_i (active),
        .fall_o     (pin_fall)
    );

    // Bundle per-source requests for the timer.
    always_comb begin
        src.supply_low = ~syn_in[0];
        src.button     = btn_pressed;
        src.pin_fall   = pin_fall;
    end

    sup_rst_timer #(.TIMEOUT(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src),
        .active_o (active)
    );

    assign rst_active_o   = active;
    assign rst_active_n_o = ~active;
    assign pin_pull_o     = active;
    assign mem_inhibit_o  = active;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
// Property checker for the reset controller, bound to the top.
// Assumes: parameters match the bound instance.
module sup_reset_ctrl_chk #(
    parameter int TIMEOUT_CYC = 50_000_000,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok_i,
    input logic rst_active_o,
    input logic rst_active_n_o
);
    logic [31:0] hold_len_q;

    // Length of the current run of asserted reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_active_o)          hold_len_q <= '0;
        else if (hold_len_q != 32'hFFFF_FFFF) hold_len_q <= hold_len_q + 1;
    end

    // R9
    outputs_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active_n_o == !rst_active_o);

    // R1
    block_reset_chk: assert property (@(posedge clk)
        !rst_n |=> rst_active_o);

    // R2
    supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!supply_ok_i, SYNC_STAGES) |=> rst_active_o);

    // R10
    min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active_o) |-> hold_len_q >= 32'(TIMEOUT_CYC));
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok_i    (supply_ok_i),
    .rst_active_o   (rst_active_o),
    .rst_active_n_o (rst_active_n_o)
);

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
    localparam int T    = 20;
    localparam int FILT = 4;
    localparam int SYN  = 2;

    logic clk = 1'b0;
    logic rst_n, supply_ok, mr_n, ext_low;
    logic pin_pull, act, act_n, inhibit;
    wire  pin_sense = ~(pin_pull | ext_low);

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sup_reset_ctrl #(.TIMEOUT_CYC(T), .MR_FILT_CYC(FILT), .SYNC_STAGES(SYN)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .mr_n_i(mr_n),
        .pin_sense_n_i(pin_sense), .pin_pull_o(pin_pull),
        .rst_active_o(act), .rst_active_n_o(act_n), .mem_inhibit_o(inhibit));

    task automatic chk(input string req, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Count consecutive high samples of reset, starting at next sample.
    task automatic run_len(output int n);
        n = 0;
        for (int i = 0; i < 10 * T; i++) begin
            @(negedge clk);
            if (act) n++;
            else break;
        end
    endtask

    // Count high samples of reset over a fixed window.
    task automatic win_count(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (act) n++;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10 * T; i++) begin
            @(negedge clk);
            if (!act) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_block_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset asserted", act, 1);
        chk("R9 low output", act_n, 0);
        chk("R9 pad pull", pin_pull, 1);
        chk("R9 inhibit", inhibit, 1);
        rst_n = 1'b1;
        run_len(n);
        chk("R1 hold after block reset", n, SYN + T - 1);
        chk("R9 idle low output", act_n, 1);
        chk("R9 idle inhibit", inhibit, 0);
    endtask

    task automatic t_supply();
        int n;
        int low_seen;
        wait_idle();
        supply_ok = 1'b0;
        @(negedge clk); chk("R2 no assert sample1", act, 0);
        @(negedge clk); chk("R2 no assert sample2", act, 0);
        @(negedge clk); chk("R2 assert sample3", act, 1);
        low_seen = 0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (!act) low_seen++;
        end
        chk("R2 held while supply low", low_seen, 0);
        supply_ok = 1'b1;
        run_len(n);
        chk("R3 supply release hold", n, SYN + T - 1);
    endtask

    task automatic t_button_short();
        int n;
        wait_idle();
        mr_n = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        mr_n = 1'b1;
        win_count(3 * T, n);
        chk("R5 short press rejected", n, 0);
    endtask

    task automatic t_button_exact();
        int n;
        wait_idle();
        mr_n = 1'b0;
        repeat (FILT) @(negedge clk);
        mr_n = 1'b1;
        win_count(3 * T, n);
        chk("R5 min press gives one timeout", n, T);
    endtask

    task automatic t_button_long();
        int n;
        wait_idle();
        mr_n = 1'b0;
        win_count(3 * T, n);
        chk("R4 held while pressed", n, 3 * T - SYN - FILT);
        mr_n = 1'b1;
        run_len(n);
        chk("R4 button release hold", n, SYN + T);
    endtask

    task automatic t_pin_pulse();
        int n;
        wait_idle();
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        chk("R6 not yet asserted", act, 0);
        @(negedge clk); chk("R6 not yet asserted 2", act, 0);
        @(negedge clk); chk("R6 asserted", act, 1);
        win_count(4 * T, n);
        chk("R6 R7 short pin pulse, no retrigger", n + 1, T);
    endtask

    task automatic t_pin_long();
        int n;
        int m;
        wait_idle();
        ext_low = 1'b1;
        win_count(3 * T, n);
        ext_low = 1'b0;
        win_count(3 * T, m);
        chk("R7 held pin does not extend", n, T);
        chk("R7 pin release no retrigger", m, 0);
    endtask

    task automatic t_expiry_race();
        int n;
        wait_idle();
        mr_n = 1'b0;
        repeat (FILT + 10) @(negedge clk);
        mr_n = 1'b1;
        repeat (T) @(negedge clk);
        supply_ok = 1'b0;
        win_count(6, n);
        chk("R8 trigger on expiry edge wins", n, 6);
        supply_ok = 1'b1;
        run_len(n);
        chk("R8 restart after race", n, SYN + T - 1);
    endtask

    task automatic t_combined();
        int n;
        wait_idle();
        supply_ok = 1'b0;
        mr_n = 1'b0;
        repeat (10) @(negedge clk);
        supply_ok = 1'b1;
        repeat (5) @(negedge clk);
        mr_n = 1'b1;
        run_len(n);
        chk("R11 last source sets release", n, SYN + T);
    endtask

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; mr_n = 1'b1; ext_low = 1'b0;
        t_block_reset();
        t_supply();
        t_button_short();
        t_button_exact();
        t_button_long();
        t_pin_pulse();
        t_pin_long();
        t_expiry_race();
        t_combined();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule